// File: doc/BRIEF.md
# Dual-Port Pixel Output Formatter

This block sits at the end of a display pipeline. It takes processed RGB pixels and their timing signals, and formats them for a panel interface that has two pixel output ports, A and B. In single-wide mode each incoming pixel leaves on one selected port, one cycle later, and the other port stays at zero. In double-wide mode the incoming pixels are grouped in pairs. The first pixel of a pair is the left pixel and the second is the right pixel. Each complete pair goes out on A and B together, and a routing bit can exchange the two sides.

Every pixel passes through three colour operations in a fixed order: an optional R/B swap, a right shift of each colour, and an optional bit reversal of each colour. Vsync, hsync and data enable each get their own output polarity. A clock-invert flag is passed on as a registered output. A per-pixel data-invert indication can be shared between the two ports or kept separate for each port. Two enables force either the timing outputs or the data outputs to zero. All configuration inputs are static levels that a register file elsewhere in the chip drives.

Top module: `pix_out_fmt`

## Requirements
- R1: After reset, and before any pixel is accepted, out_valid, out_a, out_b, out_dinv_a, out_dinv_b, out_vs, out_hs, out_de and out_clk_inv are all 0.
- R2: With cfg_dual=0, each cycle that has in_valid=1 produces out_valid=1 on the next cycle. With cfg_route=0 the pixel appears on out_a and out_b is 0. With cfg_route=1 the pixel appears on out_b and out_a is 0.
- R3: With cfg_dual=1, the first accepted pixel of a pair is stored as left and the second is taken as right. Valid cycles need not be adjacent. out_valid rises only on the cycle after the right pixel is accepted. With cfg_route=0 the left pixel goes to A and the right pixel to B. With cfg_route=1 the two sides are exchanged.
- R4: cfg_shift codes 0 to 4 shift each 8-bit colour right by that many places, filling with zeros. Codes 5 to 7 apply no shift.
- R5: With cfg_rev=1, bit i of each colour moves to bit 7-i. The reversal is applied after the shift.
- R6: With cfg_swap_rb=1, the R and B components are exchanged before the shift. Pixels are packed as R in bits [23:16], G in [15:8] and B in [7:0].
- R7: On every cycle, out_vs, out_hs and out_de each equal the previous cycle's input XOR its own polarity bit, as long as cfg_tcon_en was 1.
- R8: When cfg_tcon_en=0 on a cycle, out_vs, out_hs and out_de are 0 on the next cycle.
- R9: When cfg_data_en=0 on a cycle, out_a, out_b, out_dinv_a and out_dinv_b are 0 on the next cycle. This also applies to values held from an earlier pixel.
- R10: A port's data-invert flag is (in_dinv AND cfg_dinv_en) of the pixel routed to that port, XOR cfg_dinv_pol. In double-wide mode with cfg_dinv_sep=0, both ports instead use the OR of the two flags of the pair. In single-wide mode the inactive port's raw flag is 0, so that port outputs cfg_dinv_pol.
- R11: out_clk_inv equals the previous cycle's cfg_clk_inv.
- R12: Clearing cfg_dual discards a pending left pixel. After re-entering double-wide mode, the next accepted pixel starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 24 | Input pixel, R/G/B packed high to low |
| in_dinv | input | 1 | Per-pixel data-invert indication |
| in_vs | input | 1 | Vertical sync in |
| in_hs | input | 1 | Horizontal sync in |
| in_de | input | 1 | Data enable in |
| cfg_dual | input | 1 | 0: single-wide, 1: double-wide |
| cfg_route | input | 1 | Active-port select / left-right exchange |
| cfg_shift | input | 3 | Right-shift code per colour |
| cfg_rev | input | 1 | Reverse bit order per colour |
| cfg_swap_rb | input | 1 | Swap R and B |
| cfg_vs_pol | input | 1 | Vsync polarity |
| cfg_hs_pol | input | 1 | Hsync polarity |
| cfg_de_pol | input | 1 | Data-enable polarity |
| cfg_clk_inv | input | 1 | Clock-invert flag |
| cfg_dinv_sep | input | 1 | 0: shared data-invert flag, 1: separate per port |
| cfg_dinv_pol | input | 1 | Data-invert output polarity |
| cfg_dinv_en | input | 1 | Data-invert enable |
| cfg_tcon_en | input | 1 | 0: timing outputs forced to zero |
| cfg_data_en | input | 1 | 0: data outputs forced to zero |
| out_valid | output | 1 | New pixel or pair on the ports |
| out_a | output | 24 | Port A pixel |
| out_b | output | 24 | Port B pixel |
| out_dinv_a | output | 1 | Port A data-invert flag |
| out_dinv_b | output | 1 | Port B data-invert flag |
| out_vs | output | 1 | Vertical sync out |
| out_hs | output | 1 | Horizontal sync out |
| out_de | output | 1 | Data enable out |
| out_clk_inv | output | 1 | Registered clock-invert flag |

## Verification
The bench sweeps all eight shift codes in every combination with swap and reversal. A design that shifts by the reserved codes, or that applies swap, shift and reversal in a different order, returns colours that do not match the model. Double-wide pairs are sent with idle gaps between the two halves and under both routing values. A design that emits on the wrong beat, or that puts left on the wrong port, desynchronises the scoreboard. The bench also abandons a half-filled pair by leaving double-wide mode, holds stale data while cfg_data_en drops, and toggles the shared and separate invert modes. These cases catch a design that keeps a stale left pixel, leaks held pixels past the gate, or uses the wrong data-invert flag.

// File: rtl/pof_pkg.sv
package pof_pkg;
    typedef enum logic {PH_LEFT = 1'b0, PH_RIGHT = 1'b1} pair_ph_e;
    localparam int SYNC_N = 3;
    localparam int SY_VS  = 0;
    localparam int SY_HS  = 1;
    localparam int SY_DE  = 2;
endpackage

// File: rtl/pof_pix_proc.sv
module pof_pix_proc #(
    parameter int CW     = 8,
    parameter int SHW    = 3,
    parameter int MAX_SH = 4
) (
    input  logic [3*CW-1:0] pix_i,
    input  logic [SHW-1:0]  shift_i,
    input  logic            rev_i,
    input  logic            swap_i,
    output logic [3*CW-1:0] pix_o
);
    localparam int PW = 3 * CW;

    logic [PW-1:0]  sw;
    logic [SHW-1:0] amt;

    // swap R and B before anything else
    always_comb begin
        sw  = swap_i ? {pix_i[CW-1:0], pix_i[2*CW-1:CW], pix_i[PW-1:2*CW]} : pix_i;
        amt = (shift_i > SHW'(MAX_SH)) ? '0 : shift_i;
    end

    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        logic [CW-1:0] sh;
        logic [CW-1:0] rv;
        always_comb begin
            sh = sw[ch*CW +: CW] >> amt;
            for (int i = 0; i < CW; i++) begin
                rv[i] = sh[CW-1-i];
            end
        end
        assign pix_o[ch*CW +: CW] = rev_i ? rv : sh;
    end
endmodule

// File: rtl/pof_pair_route.sv
module pof_pair_route #(
    parameter int PW = 24
) (
    input  logic          dual_i,
    input  logic          route_i,
    input  logic          sep_i,
    input  logic [PW-1:0] cur_pix_i,
    input  logic          cur_flag_i,
    input  logic [PW-1:0] left_pix_i,
    input  logic          left_flag_i,
    output logic [PW-1:0] a_o,
    output logic [PW-1:0] b_o,
    output logic          fa_o,
    output logic          fb_o
);
    logic fl, fr;

    always_comb begin
        fl = sep_i ? left_flag_i : (left_flag_i | cur_flag_i);
        fr = sep_i ? cur_flag_i  : (left_flag_i | cur_flag_i);
        if (!dual_i) begin
            a_o  = route_i ? '0 : cur_pix_i;
            b_o  = route_i ? cur_pix_i : '0;
            fa_o = route_i ? 1'b0 : cur_flag_i;
            fb_o = route_i ? cur_flag_i : 1'b0;
        end else if (!route_i) begin
            a_o  = left_pix_i;
            b_o  = cur_pix_i;
            fa_o = fl;
            fb_o = fr;
        end else begin
            a_o  = cur_pix_i;
            b_o  = left_pix_i;
            fa_o = fr;
            fb_o = fl;
        end
    end
endmodule

// File: rtl/pof_sync_pol.sv
module pof_sync_pol #(
    parameter int N = 3
) (
    input  logic [N-1:0] sig_i,
    input  logic [N-1:0] pol_i,
    input  logic         en_i,
    output logic [N-1:0] sig_o
);
    for (genvar k = 0; k < N; k++) begin : g_sig
        assign sig_o[k] = en_i & (sig_i[k] ^ pol_i[k]);
    end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
    import pof_pkg::*;
#(
    parameter int CW     = 8,
    parameter int SHW    = 3,
    parameter int MAX_SH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3*CW-1:0]   in_pix,
    input  logic              in_dinv,
    input  logic              in_vs,
    input  logic              in_hs,
    input  logic              in_de,
    input  logic              cfg_dual,
    input  logic              cfg_route,
    input  logic [SHW-1:0]    cfg_shift,
    input  logic              cfg_rev,
    input  logic              cfg_swap_rb,
    input  logic              cfg_vs_pol,
    input  logic              cfg_hs_pol,
    input  logic              cfg_de_pol,
    input  logic              cfg_clk_inv,
    input  logic              cfg_dinv_sep,
    input  logic              cfg_dinv_pol,
    input  logic              cfg_dinv_en,
    input  logic              cfg_tcon_en,
    input  logic              cfg_data_en,
    output logic              out_valid,
    output logic [3*CW-1:0]   out_a,
    output logic [3*CW-1:0]   out_b,
    output logic              out_dinv_a,
    output logic              out_dinv_b,
    output logic              out_vs,
    output logic              out_hs,
    output logic              out_de,
    output logic              out_clk_inv
);
    localparam int PW = 3 * CW;

    typedef struct packed {
        pair_ph_e      phase;
        logic [PW-1:0] left;
        logic          left_f;
        logic [PW-1:0] a;
        logic [PW-1:0] b;
        logic          fa;
        logic          fb;
        logic          vs;
        logic          hs;
        logic          de;
        logic          clk_inv;
        logic          valid;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0]     cur_pix;
    logic              cur_flag;
    logic [PW-1:0]     rt_a, rt_b;
    logic              rt_fa, rt_fb;
    logic [SYNC_N-1:0] sync_in, sync_pol, sync_out;

    assign cur_flag = cfg_dinv_en & in_dinv;

    pof_pix_proc #(.CW(CW), .SHW(SHW), .MAX_SH(MAX_SH)) u_proc (
        .pix_i   (in_pix),
        .shift_i (cfg_shift),
        .rev_i   (cfg_rev),
        .swap_i  (cfg_swap_rb),
        .pix_o   (cur_pix)
    );

    pof_pair_route #(.PW(PW)) u_route (
        .dual_i      (cfg_dual),
        .route_i     (cfg_route),
        .sep_i       (cfg_dinv_sep),
        .cur_pix_i   (cur_pix),
        .cur_flag_i  (cur_flag),
        .left_pix_i  (st_q.left),
        .left_flag_i (st_q.left_f),
        .a_o         (rt_a),
        .b_o         (rt_b),
        .fa_o        (rt_fa),
        .fb_o        (rt_fb)
    );

    always_comb begin
        sync_in         = '0;
        sync_pol        = '0;
        sync_in[SY_VS]  = in_vs;
        sync_in[SY_HS]  = in_hs;
        sync_in[SY_DE]  = in_de;
        sync_pol[SY_VS] = cfg_vs_pol;
        sync_pol[SY_HS] = cfg_hs_pol;
        sync_pol[SY_DE] = cfg_de_pol;
    end

    pof_sync_pol #(.N(SYNC_N)) u_sync (
        .sig_i (sync_in),
        .pol_i (sync_pol),
        .en_i  (cfg_tcon_en),
        .sig_o (sync_out)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.vs      = sync_out[SY_VS];
        st_d.hs      = sync_out[SY_HS];
        st_d.de      = sync_out[SY_DE];
        st_d.clk_inv = cfg_clk_inv;
        if (!cfg_dual) begin
            st_d.phase = PH_LEFT;
        end
        if (in_valid) begin
            if (cfg_dual && st_q.phase == PH_LEFT) begin
                st_d.left   = cur_pix;
                st_d.left_f = cur_flag;
                st_d.phase  = PH_RIGHT;
            end else begin
                st_d.valid = 1'b1;
                st_d.a     = rt_a;
                st_d.b     = rt_b;
                st_d.fa    = rt_fa ^ cfg_dinv_pol;
                st_d.fb    = rt_fb ^ cfg_dinv_pol;
                st_d.phase = PH_LEFT;
            end
        end
        if (!cfg_data_en) begin
            st_d.a  = '0;
            st_d.b  = '0;
            st_d.fa = 1'b0;
            st_d.fb = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_a       = st_q.a;
    assign out_b       = st_q.b;
    assign out_dinv_a  = st_q.fa;
    assign out_dinv_b  = st_q.fb;
    assign out_vs      = st_q.vs;
    assign out_hs      = st_q.hs;
    assign out_de      = st_q.de;
    assign out_clk_inv = st_q.clk_inv;
endmodule

// File: rtl/pof_chk.sv
module pof_chk #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_vs,
    input logic          cfg_dual,
    input logic          cfg_route,
    input logic          cfg_vs_pol,
    input logic          cfg_clk_inv,
    input logic          cfg_tcon_en,
    input logic          cfg_data_en,
    input logic          out_valid,
    input logic [PW-1:0] out_a,
    input logic [PW-1:0] out_b,
    input logic          out_dinv_a,
    input logic          out_dinv_b,
    input logic          out_vs,
    input logic          out_hs,
    input logic          out_de,
    input logic          out_clk_inv
);
    // R2
    single_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && in_valid) |=> out_valid);

    // R2
    single_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && in_valid && !cfg_route && cfg_data_en) |=> (out_b == '0));

    // R3
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    vs_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tcon_en |=> (out_vs == $past(in_vs ^ cfg_vs_pol)));

    // R8
    tcon_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tcon_en |=> (!out_vs && !out_hs && !out_de));

    // R9
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_data_en |=> (out_a == '0 && out_b == '0 && !out_dinv_a && !out_dinv_b));

    // R11
    clk_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_clk_inv == $past(cfg_clk_inv)));
endmodule

bind pix_out_fmt pof_chk #(.PW(3 * CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_vs       (in_vs),
    .cfg_dual    (cfg_dual),
    .cfg_route   (cfg_route),
    .cfg_vs_pol  (cfg_vs_pol),
    .cfg_clk_inv (cfg_clk_inv),
    .cfg_tcon_en (cfg_tcon_en),
    .cfg_data_en (cfg_data_en),
    .out_valid   (out_valid),
    .out_a       (out_a),
    .out_b       (out_b),
    .out_dinv_a  (out_dinv_a),
    .out_dinv_b  (out_dinv_b),
    .out_vs      (out_vs),
    .out_hs      (out_hs),
    .out_de      (out_de),
    .out_clk_inv (out_clk_inv)
);

// File: tb/tb_pix_out_fmt.sv
module tb_pix_out_fmt;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        in_valid = 0, in_dinv = 0, in_vs = 0, in_hs = 0, in_de = 0;
    logic [23:0] in_pix = '0;
    logic        cfg_dual = 0, cfg_route = 0, cfg_rev = 0, cfg_swap_rb = 0;
    logic [2:0]  cfg_shift = '0;
    logic        cfg_vs_pol = 0, cfg_hs_pol = 0, cfg_de_pol = 0, cfg_clk_inv = 0;
    logic        cfg_dinv_sep = 0, cfg_dinv_pol = 0, cfg_dinv_en = 0;
    logic        cfg_tcon_en = 0, cfg_data_en = 0;
    logic        out_valid, out_dinv_a, out_dinv_b, out_vs, out_hs, out_de, out_clk_inv;
    logic [23:0] out_a, out_b;

    pix_out_fmt dut (.*);

    // model configuration, applied to the ports on each beat
    logic       m_dual = 0, m_route = 0, m_rev = 0, m_swap = 0;
    logic [2:0] m_shift = 0;
    logic       m_vsp = 0, m_hsp = 0, m_dep = 0, m_ck = 0;
    logic       m_sep = 0, m_dpol = 0, m_den = 0, m_tcon = 1, m_data = 1;
    string      m_tag = "R2";

    int checks = 0, errors = 0;
    logic ph = 0;
    logic [23:0] lp;
    logic        lf;

    logic [49:0] pq[$];   // {a, b, fa, fb}
    string       pt[$];
    logic [3:0]  tq[$];   // {vs, hs, de, ck}

    function automatic logic [23:0] proc(input logic [23:0] p);
        logic [23:0] s, o;
        int amt;
        s   = m_swap ? {p[7:0], p[15:8], p[23:16]} : p;
        amt = (m_shift <= 3'd4) ? int'(m_shift) : 0;
        for (int c = 0; c < 3; c++) begin
            logic [7:0] v;
            v = s[c*8 +: 8] >> amt;
            for (int i = 0; i < 8; i++) o[c*8 + i] = m_rev ? v[7-i] : v[i];
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic [23:0] p, input logic df,
                        input logic vs, input logic hs, input logic de);
        logic [23:0] cp, a, b;
        logic        cf, fa, fb, fl, fr;
        @(negedge clk);
        in_valid = v; in_pix = p; in_dinv = df; in_vs = vs; in_hs = hs; in_de = de;
        cfg_dual = m_dual; cfg_route = m_route; cfg_rev = m_rev; cfg_swap_rb = m_swap;
        cfg_shift = m_shift; cfg_vs_pol = m_vsp; cfg_hs_pol = m_hsp; cfg_de_pol = m_dep;
        cfg_clk_inv = m_ck; cfg_dinv_sep = m_sep; cfg_dinv_pol = m_dpol; cfg_dinv_en = m_den;
        cfg_tcon_en = m_tcon; cfg_data_en = m_data;
        tq.push_back({m_tcon & (vs ^ m_vsp), m_tcon & (hs ^ m_hsp), m_tcon & (de ^ m_dep), m_ck});
        if (!m_dual) ph = 0;
        if (v) begin
            cp = proc(p);
            cf = m_den & df;
            if (m_dual && !ph) begin
                lp = cp; lf = cf; ph = 1;
            end else begin
                if (!m_dual) begin
                    a  = m_route ? 24'h0 : cp;  b  = m_route ? cp : 24'h0;
                    fa = m_route ? 1'b0 : cf;   fb = m_route ? cf : 1'b0;
                end else begin
                    fl = m_sep ? lf : (lf | cf);
                    fr = m_sep ? cf : (lf | cf);
                    a  = m_route ? cp : lp;  b  = m_route ? lp : cp;
                    fa = m_route ? fr : fl;  fb = m_route ? fl : fr;
                end
                fa ^= m_dpol; fb ^= m_dpol;
                if (!m_data) begin a = 0; b = 0; fa = 0; fb = 0; end
                pq.push_back({a, b, fa, fb});
                pt.push_back(m_tag);
                ph = 0;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat(0, 24'h0, 0, 0, 0, 0);
    endtask

    // monitor: compare against the scoreboard after each edge
    logic [49:0] e;
    logic [3:0]  te;
    string       tg;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (tq.size() > 0) begin
                te = tq.pop_front();
                check("R7/R8/R11 timing", {60'h0, out_vs, out_hs, out_de, out_clk_inv}, {60'h0, te});
            end
            if (out_valid) begin
                if (pq.size() == 0) begin
                    check("R3 unexpected out_valid", 64'h1, 64'h0);
                end else begin
                    e  = pq.pop_front();
                    tg = pt.pop_front();
                    check(tg, {14'h0, out_a, out_b, out_dinv_a, out_dinv_b}, {14'h0, e});
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #2;
        // R1 reset state
        check("R1", {55'h0, out_valid, out_dinv_a, out_dinv_b, out_vs, out_hs, out_de, out_clk_inv, 2'b0},
              64'h0);
        check("R1 ports", {16'h0, out_a, out_b}, 64'h0);

        // R2 single-wide, port A then port B
        m_tag = "R2 single A";
        for (int i = 0; i < 6; i++) beat(1, $urandom, 0, 0, 0, 1);
        idle(1);
        m_route = 1; m_tag = "R2 single B";
        for (int i = 0; i < 6; i++) beat(i % 2 == 0, $urandom, 0, 0, 0, 1);
        m_route = 0;

        // R4 R5 R6 shift, reversal and swap sweep
        for (int k = 0; k < 32; k++) begin
            m_shift = k[2:0]; m_rev = k[3]; m_swap = k[4];
            m_tag = "R4/R5/R6 colour ops";
            beat(1, $urandom, 0, 0, 0, 1);
            beat(1, 24'hFF8001, 0, 0, 0, 1);
        end
        m_shift = 0; m_rev = 0; m_swap = 0;
        idle(2);

        // R3 double-wide pairs, both routings, with gaps
        m_dual = 1; m_tag = "R3 pair route0";
        for (int i = 0; i < 8; i++) begin
            beat(1, $urandom, 0, 0, 1, 1);
            if (i % 3 == 0) idle(2);
        end
        m_route = 1; m_tag = "R3 pair route1";
        for (int i = 0; i < 8; i++) begin
            beat(1, $urandom, 0, 0, 1, 1);
            if (i % 2 == 1) idle(1);
        end
        m_route = 0;

        // R10 data-invert: shared, separate, polarity, enable
        for (int k = 0; k < 16; k++) begin
            m_sep = k[0]; m_dpol = k[1]; m_den = k[2]; m_dual = k[3];
            m_tag = "R10 data invert";
            for (int j = 0; j < 4; j++) beat(1, $urandom, j[0] ^ k[1], 0, 0, 1);
        end
        m_dpol = 0; m_den = 0; m_sep = 0;

        // R12 abandon half pair
        m_dual = 1; m_tag = "R12 pending left";
        beat(1, 24'h111111, 0, 0, 0, 1);
        m_dual = 0; m_tag = "R12 single after abort";
        beat(1, 24'h222222, 0, 0, 0, 1);
        m_dual = 1; m_tag = "R12 fresh pair";
        beat(1, 24'h333333, 0, 0, 0, 1);
        beat(1, 24'h444444, 0, 0, 0, 1);
        m_dual = 0;
        idle(1);

        // R7 R11 polarities and clock-invert flag
        for (int k = 0; k < 32; k++) begin
            m_vsp = k[0]; m_hsp = k[1]; m_dep = k[2]; m_ck = k[3];
            beat(k[4], $urandom, 0, k[1], k[2] ^ k[0], k[3]);
        end
        // R8 timing gate
        m_tcon = 0;
        for (int k = 0; k < 8; k++) beat(1, $urandom, 0, k[0], k[1], k[2]);
        m_tcon = 1; m_vsp = 0; m_hsp = 0; m_dep = 0; m_ck = 0;

        // R9 data gate including held value
        m_tag = "R9 before gate";
        beat(1, 24'hABCDEF, 1, 0, 0, 1);
        m_data = 0;
        idle(1);
        @(posedge clk); #2;
        check("R9 held cleared", {16'h0, out_a, out_b}, 64'h0);
        m_tag = "R9 gated";
        m_den = 1; m_dpol = 1;
        for (int i = 0; i < 4; i++) beat(1, $urandom, 1, 0, 0, 1);
        m_data = 1; m_den = 0; m_dpol = 0;
        idle(4);

        check("scoreboard drained", {32'h0, 32'(pq.size())}, 64'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule